// File: doc/BRIEF.md
# System Clock Prescaler

This block derives the system clock rate from a faster master clock by a power-of-two factor. It does not make a second clock. It gives out a one-cycle enable pulse at the master rate, and every synchronous consumer advances only on that pulse. The factor comes from a 4-bit select register. Software can rewrite the register at any time while the divider keeps running.

A configuration input, normally tied to a fuse, picks the value the select register takes at reset. With the fuse low the block starts at full speed. With the fuse high it starts at one eighth speed, so a fast clock source cannot overrun the rest of the chip before software has chosen a rate. A new factor is applied only when the current divided period ends. Because of this, no interval between enable pulses is ever shorter than the old setting or the new one would give.

Top module: `sysclk_prescaler`

## Requirements
- R1: On a clock edge with `rst_i` high and `fuse_i` low, `sel_o` becomes 4'd0 (factor 1).
- R2: On a clock edge with `rst_i` high and `fuse_i` high, `sel_o` becomes 4'd3 (factor 8).
- R3: A write (`wr_en_i` high) with `wr_data_i` from 0 to 8 sets `sel_o` to `wr_data_i` in the following cycle, whatever the level of `fuse_i`.
- R4: A write with `wr_data_i` from 9 to 15 is ignored, and `sel_o` keeps its previous value.
- R5: With select value s applied, `tick_o` is high for exactly one cycle in every 2^s cycles.
- R6: With select 0 applied, `tick_o` stays high in every cycle.
- R7: A new select value takes effect only when the current divided period ends. Each interval between two `tick_o` pulses equals the factor that was in force when that interval began.
- R8: `tick_o` is low in the first cycle after reset. The first pulse comes 2^s cycles after reset, where s is the reset select value.
- R9: A write that arrives while `rst_i` is high has no effect, so `sel_o` shows the reset value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fuse_i | input | 1 | Reset-value select: high starts at factor 8, low starts at factor 1 |
| wr_en_i | input | 1 | Select register write strobe |
| wr_data_i | input | 4 | Select value to write (legal values 0 to 8) |
| tick_o | output | 1 | One-cycle system clock enable |
| sel_o | output | 4 | Current select register value |

## Verification
The bench builds the block with its default parameters: a 4-bit select and a maximum select of 8. This brings the full 1-to-256 range of factors and all seven reserved codes within reach in a short run. The bench measures the pulse spacing of every legal factor and applies both fuse levels across several resets. It also writes to the select register in the middle of long periods, and in the same cycle as a period boundary, so that the rule for applying a factor only at a boundary is tested at both ends.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  localparam int unsigned DEF_SEL_W   = 4;
  localparam int unsigned DEF_MAX_SEL = 8;
  localparam int unsigned DEF_FUSED   = 3;

  // Division factor for a given select code.
  function automatic int unsigned factor_of(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

endpackage

// File: rtl/prescale_sel_reg.sv
module prescale_sel_reg #(
  parameter int unsigned SEL_W   = prescale_pkg::DEF_SEL_W,
  parameter int unsigned MAX_SEL = prescale_pkg::DEF_MAX_SEL
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] rst_sel_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_data_i,
  output logic [SEL_W-1:0] sel_q_o
);

  localparam logic [SEL_W-1:0] LIMIT = SEL_W'(MAX_SEL);

  logic legal;
  assign legal = (wr_data_i <= LIMIT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_q_o <= rst_sel_i;
    end else if (wr_en_i && legal) begin
      sel_q_o <= wr_data_i;
    end
  end

endmodule

// File: rtl/prescale_terminal.sv
module prescale_terminal #(
  parameter int unsigned SEL_W   = prescale_pkg::DEF_SEL_W,
  parameter int unsigned MAX_SEL = prescale_pkg::DEF_MAX_SEL,
  localparam int unsigned CNT_W  = (MAX_SEL > 0) ? MAX_SEL : 1
) (
  input  logic [SEL_W-1:0] act_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             last_o
);

  logic [MAX_SEL:0] hit;

  // One decode per factor: the count is always below the factor, so the
  // last count of a period is the low s bits all ones.
  for (genvar g = 0; g <= MAX_SEL; g++) begin : g_hit
    if (g == 0) begin : g_one
      assign hit[g] = (act_i == SEL_W'(g));
    end else begin : g_pow
      assign hit[g] = (act_i == SEL_W'(g)) && (&cnt_i[g-1:0]);
    end
  end

  assign last_o = |hit;

endmodule

// File: rtl/prescale_counter.sv
module prescale_counter #(
  parameter int unsigned SEL_W   = prescale_pkg::DEF_SEL_W,
  parameter int unsigned MAX_SEL = prescale_pkg::DEF_MAX_SEL,
  localparam int unsigned CNT_W  = (MAX_SEL > 0) ? MAX_SEL : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] rst_sel_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] act_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             last;

  prescale_terminal #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) term_i (
    .act_i (act_o),
    .cnt_i (cnt_q),
    .last_o(last)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      act_o  <= rst_sel_i;
      tick_o <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      act_o  <= sel_i;   // new factor only at a period boundary
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
  parameter int unsigned SEL_W   = prescale_pkg::DEF_SEL_W,
  parameter int unsigned MAX_SEL = prescale_pkg::DEF_MAX_SEL,
  parameter int unsigned FUSED   = prescale_pkg::DEF_FUSED
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             fuse_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_data_i,
  output logic             tick_o,
  output logic [SEL_W-1:0] sel_o
);

  logic [SEL_W-1:0] rst_sel;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] act_sel;

  assign rst_sel = fuse_i ? SEL_W'(FUSED) : '0;

  prescale_sel_reg #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) sel_reg_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rst_sel_i(rst_sel),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .sel_q_o  (sel_q)
  );

  prescale_counter #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) cnt_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rst_sel_i(rst_sel),
    .sel_i    (sel_q),
    .act_o    (act_sel),
    .tick_o   (tick_o)
  );

  assign sel_o = sel_q;

endmodule

// File: rtl/prescale_chk.sv
module prescale_chk #(
  parameter int unsigned SEL_W   = prescale_pkg::DEF_SEL_W,
  parameter int unsigned MAX_SEL = prescale_pkg::DEF_MAX_SEL,
  parameter int unsigned FUSED   = prescale_pkg::DEF_FUSED
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             fuse_i,
  input logic             wr_en_i,
  input logic [SEL_W-1:0] wr_data_i,
  input logic             tick_o,
  input logic [SEL_W-1:0] sel_o,
  input logic [SEL_W-1:0] act_sel
);

  localparam int unsigned GAP_W = MAX_SEL + 2;

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] fac_q;
  logic             seen_q;

  // Measures the distance between enable pulses and records the factor
  // in force at the start of each interval.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap_q  <= '0;
      fac_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q <= tick_o ? GAP_W'(1) : gap_q + 1'b1;
      if (tick_o) begin
        fac_q  <= GAP_W'(1) << act_sel;
        seen_q <= 1'b1;
      end
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(rst_i) && !$past(fuse_i)) |-> (sel_o == '0));

  // R2
  reset_fused_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(rst_i) && $past(fuse_i)) |-> (sel_o == SEL_W'(FUSED)));

  // R3
  legal_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_data_i <= SEL_W'(MAX_SEL)) |=> (sel_o == $past(wr_data_i)));

  // R4
  reserved_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_data_i > SEL_W'(MAX_SEL)) |=> $stable(sel_o));

  // R5
  active_legal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    act_sel <= SEL_W'(MAX_SEL));

  // R7
  interval_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen_q && tick_o) |-> (gap_q == fac_q));

  // R8
  first_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> !tick_o);

endmodule

bind sysclk_prescaler prescale_chk #(
  .SEL_W(SEL_W), .MAX_SEL(MAX_SEL), .FUSED(FUSED)
) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .fuse_i   (fuse_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .tick_o   (tick_o),
  .sel_o    (sel_o),
  .act_sel  (act_sel)
);

// File: tb/sysclk_prescaler_tb_top.sv
module sysclk_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       fuse = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'd0;
  logic       tick;
  logic [3:0] sel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sysclk_prescaler dut_i (
    .clk_i(clk), .rst_i(rst), .fuse_i(fuse),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tick_o(tick), .sel_o(sel)
  );

  // Behavioural reference: cycles left until the next pulse.
  bit model_ok = 1'b0;
  int m_sel = 0;
  int m_left = 1;
  bit m_tick = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_sel    = fuse ? 3 : 0;
      m_left   = 1 << m_sel;
      m_tick   = 1'b0;
      model_ok = 1'b1;
    end else begin
      int old_sel;
      old_sel = m_sel;
      m_left  = m_left - 1;
      if (m_left == 0) begin
        m_tick = 1'b1;
        m_left = 1 << old_sel;
      end else begin
        m_tick = 1'b0;
      end
      if (wr_en && wr_data <= 4'd8) m_sel = int'(wr_data);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R5 R7 R3).
  always @(negedge clk) begin
    if (model_ok && !done) begin
      check(tick == m_tick, "R5/R7 tick vs model", int'(tick), int'(m_tick));
      check(int'(sel) == m_sel, "R3/R4 sel vs model", int'(sel), m_sel);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input bit f);
    @(negedge clk);
    fuse = f; rst = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic wr(input int v);
    wr_en = 1'b1; wr_data = 4'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 600 && !tick; i++) @(negedge clk);
  endtask

  // Returns cycles between two consecutive pulses.
  task automatic measure(output int gap);
    wait_tick();
    gap = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      gap++;
      if (tick) break;
    end
  endtask

  initial begin
    int g;
    cyc(1);

    // R1, R8
    do_reset(1'b0);
    check(sel == 4'd0, "R1 reset sel fuse low", int'(sel), 0);
    check(tick == 1'b0, "R8 tick low after reset", int'(tick), 0);
    cyc(1);
    check(tick == 1'b1, "R8 first pulse at factor 1", int'(tick), 1);
    // R6
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      check(tick == 1'b1, "R6 tick held at factor 1", int'(tick), 1);
    end

    // R2, R8
    do_reset(1'b1);
    check(sel == 4'd3, "R2 reset sel fuse high", int'(sel), 3);
    check(tick == 1'b0, "R8 tick low after fused reset", int'(tick), 0);
    g = 1;
    for (int i = 0; i < 20 && !tick; i++) begin cyc(1); g++; end
    check(g == 9, "R8 first pulse cycle count at factor 8", g, 9);

    // R3, R5: every legal factor, fuse still high
    for (int s = 0; s <= 8; s++) begin
      wr(s);
      check(int'(sel) == s, "R3 write readback", int'(sel), s);
      measure(g); measure(g);
      check(g == (1 << s), "R5 period for select", g, 1 << s);
    end

    // R4: reserved codes
    wr(5);
    for (int v = 9; v <= 15; v++) begin
      wr(v);
      check(sel == 4'd5, "R4 reserved write ignored", int'(sel), 5);
    end
    measure(g);
    check(g == 32, "R4 factor kept after reserved", g, 32);

    // R7: mid-period changes, fast and slow
    wr(6); measure(g); measure(g);
    cyc(10);
    wr(1);
    measure(g);
    check(g == 2, "R7 new factor after old period", g, 2);
    wr(7); cyc(1);
    wr(0);
    measure(g);
    check(g == 1 || g == 128, "R7 no short interval", g, 1);
    // write exactly on a boundary cycle
    wr(4); measure(g); measure(g);
    wait_tick();
    wr(2);
    measure(g);
    check(g == 16 || g == 4, "R7 boundary write", g, 4);

    // R9: write during reset
    @(negedge clk);
    rst = 1'b1; fuse = 1'b0; wr_en = 1'b1; wr_data = 4'd6;
    cyc(2);
    rst = 1'b0; wr_en = 1'b0;
    check(sel == 4'd0, "R9 write in reset ignored", int'(sel), 0);
    cyc(20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule